// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplex Mode

This block holds a vector of independent output bits (eight by default). A single data bit is steered into the bit picked by a binary select code. Two active-low controls, a write enable and a zeroing control, pick one of four update modes per clock: steer the data into the selected bit and keep the rest, hold everything, steer the data into the selected bit and zero the rest (demultiplex), or zero everything.

The level-sensitive behaviour is modelled as registers that sample all controls, the select code and the data bit on every rising clock edge. The modes are the states of the block. WRITE is entered when the zeroing control is high and the enable is low. HOLD is entered when both are high. DEMUX is entered when both are low. CLEAR is entered when the zeroing control is low and the enable is high. Any state can pass to any other on the next edge, and the inputs alone choose it. A synchronous system reset forces the bits to zero and the state to HOLD. The applied mode is also driven out as a 2-bit code.

Top module: `bit_steer_latch`

## Requirements
- R1: With zero_n=1 and wr_en_n=0 (WRITE), at the rising edge the bit chosen by sel takes din and every other bit keeps its value.
- R2: With zero_n=1 and wr_en_n=1 (HOLD), no bit changes at the edge, whatever sel and din are.
- R3: With zero_n=0 and wr_en_n=1 (CLEAR), all bits become 0 at the edge, whatever sel and din are.
- R4: With zero_n=0 and wr_en_n=0 (DEMUX), the bit chosen by sel takes din and every other bit becomes 0.
- R5: sel is plain binary with bit 2 as MSB: code 0 addresses bits[0] and code 7 addresses bits[7], ascending.
- R6: Outputs change only at a rising clock edge. An input change between edges has no effect on bits until the next edge.
- R7: mode reports the state applied at the last edge, encoded 00 WRITE, 01 HOLD, 10 DEMUX, 11 CLEAR.
- R8: While the synchronous rst is high at an edge, bits become all 0 and mode becomes 01 (HOLD), overriding all other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Data bit to steer |
| sel | input | 3 | Binary select of the target bit |
| wr_en_n | input | 1 | Active-low write enable |
| zero_n | input | 1 | Active-low zeroing control |
| bits | output | 8 | Stored output bits |
| mode | output | 2 | State applied at the last edge |

## Verification
Writing the selected bit and zeroing the unselected bits can fall in the same cycle, in DEMUX. Changing state on every edge can also make a write land right after a clear or a demux. Random stimulus flips both controls independently on each cycle, so these back-to-back transitions occur often. A directed sweep covers every state with every select code and data value from a mixed starting pattern. Each cycle's bits and mode are compared against a bench model that applies the four rules to the previous expected vector.

// File: rtl/bit_steer_pkg.sv
package bit_steer_pkg;
    typedef enum logic [1:0] {
        ST_WRITE = 2'b00,
        ST_HOLD  = 2'b01,
        ST_DEMUX = 2'b10,
        ST_CLEAR = 2'b11
    } steer_state_e;
endpackage

// File: rtl/bit_steer_mode_dec.sv
module bit_steer_mode_dec
    import bit_steer_pkg::*;
(
    input  logic         wr_en_n,
    input  logic         zero_n,
    output steer_state_e next_state
);
    always_comb begin
        unique case ({zero_n, wr_en_n})
            2'b10:   next_state = ST_WRITE;
            2'b11:   next_state = ST_HOLD;
            2'b00:   next_state = ST_DEMUX;
            default: next_state = ST_CLEAR;
        endcase
    end
endmodule

// File: rtl/bit_steer_sel_dec.sv
module bit_steer_sel_dec #(
    parameter int NBITS = 8,
    localparam int SEL_W = $clog2(NBITS)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [NBITS-1:0] hit
);
    for (genvar i = 0; i < NBITS; i++) begin : g_hit
        assign hit[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/bit_steer_cell.sv
module bit_steer_cell
    import bit_steer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  steer_state_e state_nx,
    input  logic         hit,
    input  logic         din,
    output logic         q
);
    logic q_nx;

    always_comb begin
        unique case (state_nx)
            ST_WRITE: q_nx = hit ? din : q;
            ST_HOLD:  q_nx = q;
            ST_DEMUX: q_nx = hit & din;
            ST_CLEAR: q_nx = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nx;
    end
endmodule

// File: rtl/bit_steer_latch.sv
module bit_steer_latch
    import bit_steer_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int SEL_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_en_n,
    input  logic             zero_n,
    output logic [NBITS-1:0] bits,
    output logic [1:0]       mode
);
    steer_state_e state_q, state_nx;
    logic [NBITS-1:0] hit;

    bit_steer_mode_dec u_mode (
        .wr_en_n   (wr_en_n),
        .zero_n    (zero_n),
        .next_state(state_nx)
    );

    bit_steer_sel_dec #(.NBITS(NBITS)) u_sel (
        .sel(sel),
        .hit(hit)
    );

    for (genvar i = 0; i < NBITS; i++) begin : g_cell
        bit_steer_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .state_nx(state_nx),
            .hit     (hit[i]),
            .din     (din),
            .q       (bits[i])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_nx;
    end

    // outputs
    always_comb mode = state_q;

    // checks
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    a_r1_write_keeps_others: assert property (@(posedge clk) disable iff (rst)
        (past_ok && state_q == ST_WRITE) |->
        (((bits ^ $past(bits)) & ~(NBITS'(1) << $past(sel))) == '0));
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (past_ok && state_q == ST_HOLD) |-> (bits == $past(bits)));
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLEAR) |-> (bits == '0));
    a_r4_demux_single: assert property (@(posedge clk) disable iff (rst)
        (past_ok && state_q == ST_DEMUX) |->
        ($onehot0(bits) && ((bits & ~(NBITS'(1) << $past(sel))) == '0)));
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (bits == '0 && mode == 2'b01));
endmodule

// File: tb/test_bit_steer_latch.sv
module test_bit_steer_latch;
    localparam int PERIOD = 10;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic [2:0] sel = '0;
    logic wr_en_n = 1'b1;
    logic zero_n = 1'b1;
    logic [NB-1:0] bits;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    logic [NB-1:0] exp_bits = '0;

    always #(PERIOD/2) clk = ~clk;

    bit_steer_latch i_bit_steer_latch (
        .clk(clk), .rst(rst), .din(din), .sel(sel),
        .wr_en_n(wr_en_n), .zero_n(zero_n), .bits(bits), .mode(mode)
    );

    function automatic logic [1:0] model_mode(input logic en_n, input logic zn);
        if (zn && !en_n) return 2'b00;
        if (zn && en_n)  return 2'b01;
        if (!zn && !en_n) return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [NB-1:0] model_bits(input logic [NB-1:0] cur,
        input logic d, input logic [2:0] s, input logic en_n, input logic zn);
        logic [NB-1:0] r;
        case (model_mode(en_n, zn))
            2'b00: begin r = cur; r[s] = d; end
            2'b01: r = cur;
            2'b10: begin r = '0; r[s] = d; end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic chk_bits(input string req, input logic [NB-1:0] exp);
        checks++;
        if (bits !== exp) begin
            errors++;
            $display("FAIL %s bits act=%h exp=%h", req, bits, exp);
        end
    endtask

    task automatic chk_mode(input logic [1:0] exp);
        checks++;
        if (mode !== exp) begin
            errors++;
            $display("FAIL R7 mode act=%b exp=%b", mode, exp);
        end
    endtask

    // drive at negedge, apply at posedge, sample a quarter period later
    task automatic step(input logic d, input logic [2:0] s, input logic en_n, input logic zn);
        logic [1:0] m;
        @(negedge clk);
        din = d; sel = s; wr_en_n = en_n; zero_n = zn;
        m = model_mode(en_n, zn);
        exp_bits = model_bits(exp_bits, d, s, en_n, zn);
        @(posedge clk);
        #(PERIOD/4);
        chk_bits(req_of(m), exp_bits);
        chk_mode(m);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R8: reset state
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        chk_bits("R8", '0);
        chk_mode(2'b01);
        @(negedge clk); rst = 1'b0;

        // R1: fill all ones, then clear one bit, others hold
        for (int i = 0; i < NB; i++) step(1'b1, 3'(i), 1'b0, 1'b1);
        chk_bits("R1", 8'hFF);
        step(1'b0, 3'd3, 1'b0, 1'b1);
        chk_bits("R1", 8'hF7);

        // R2: hold ignores data and select
        step(1'b0, 3'd5, 1'b1, 1'b1);
        chk_bits("R2", 8'hF7);

        // R6: change inputs between edges; no effect before the edge
        @(negedge clk);
        din = 1'b1; sel = 3'd3; wr_en_n = 1'b0; zero_n = 1'b0;
        #1;
        chk_bits("R6", 8'hF7);
        @(negedge clk);
        wr_en_n = 1'b1; zero_n = 1'b1;
        exp_bits = 8'h08;   // the edge between applied DEMUX on sel 3
        #1;
        chk_bits("R6", 8'h08);

        // R5: encoding ends
        step(1'b1, 3'd0, 1'b0, 1'b0);
        chk_bits("R5", 8'h01);
        step(1'b1, 3'd7, 1'b0, 1'b0);
        chk_bits("R5", 8'h80);

        // R3: clear ignores data and select
        step(1'b1, 3'd7, 1'b1, 1'b0);
        chk_bits("R3", 8'h00);

        // exhaustive sweep of state x select x data from a mixed pattern
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < NB; s++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int k = 0; k < NB; k++)
                        step(k[0] ^ k[1], 3'(k), 1'b0, 1'b1);
                    step(d[0], 3'(s), m[0], m[1]);
                end
            end
        end

        // random back-to-back state changes
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0], 3'($urandom), r[1], r[2] | r[3]);
        end

        // R8: reset mid-run overrides a write
        step(1'b1, 3'd2, 1'b0, 1'b1);
        @(negedge clk); rst = 1'b1; din = 1'b1; wr_en_n = 1'b0; zero_n = 1'b1;
        @(posedge clk); #(PERIOD/4);
        exp_bits = '0;
        chk_bits("R8", '0);
        chk_mode(2'b01);
        @(negedge clk); rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule